// File: doc/BRIEF.md
# Receive Interrupt Delay Timer

This block postpones the receive-complete interrupt of a receive DMA engine. The DMA signals each finished frame transfer with a one-cycle strobe. Alongside the strobe it gives a flag that says whether that frame's descriptor asked for an immediate receive interrupt. A frame that arrives without that request starts a down-counter, provided the programmed reload value is not zero. When the counter runs out, the block sends a one-cycle set pulse to the receive interrupt status bit, which lives outside this block. A later frame that does request the interrupt raises the status bit through the DMA's own path, and it cancels the pending countdown.

The reload value is counted in steps of 256 clock cycles. An internal prescaler produces these steps, so an 8-bit reload value covers delays of up to 65,280 cycles. Software writes the reload register through a simple write strobe. Writing zero disables the timer and stops a countdown that is already running.

Top module: `rx_irq_delay_timer`

## Requirements
- R1: After reset the timer is idle (`timer_active` = 0, `ri_set` = 0) and the reload value is zero, so a completion without an interrupt request does not start the timer until a non-zero value is written.
- R2: With a non-zero reload value, a `frm_done` strobe with `frm_irq_req` = 0 seen at a rising edge starts the timer. `timer_active` reads 1 after that edge.
- R3: While the reload value is zero, completions without an interrupt request leave the timer idle and produce no pulse.
- R4: A timer started at edge k with reload value N (1 to 255) raises `ri_set` for exactly one cycle after edge k + 256·N. At that same edge `timer_active` returns to 0.
- R5: Further completions without an interrupt request while the timer runs do not restart it. The deadline stays the one set by the first completion.
- R6: A completion with `frm_irq_req` = 1 while the timer runs stops it (`timer_active` = 0 after that edge), and no `ri_set` pulse follows.
- R7: Writing zero to the reload register while the timer runs stops it at that edge, with no `ri_set` pulse.
- R8: Writing a new non-zero reload value while the timer runs does not change the current deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the reload register |
| cfg_wr_data | input | RLD_W | Reload value in 256-cycle steps; zero disables |
| frm_done | input | 1 | One-cycle strobe: the DMA has finished writing a frame |
| frm_irq_req | input | 1 | The finished frame's descriptor requested an immediate interrupt; valid with `frm_done` |
| ri_set | output | 1 | One-cycle set pulse to the receive interrupt status bit |
| timer_active | output | 1 | Countdown in progress |

## Verification
The assertions assume that `frm_irq_req` only carries meaning in a cycle where `frm_done` is high. They also assume that a reload write does not fall in the same cycle as the completion that starts the timer, since the arming step samples the register value held before that edge. The directed stimulus drives every write and every frame strobe in a cycle of its own, one cycle long, and changes inputs only on falling edges. The deadline, cancel, zero-write and rewrite scenarios are timed against the arming edge, so a shift of a single cycle is detected.

// File: rtl/rxwd_pkg.sv
`timescale 1ns/1ps
package rxwd_pkg;
  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_RUN  = 1'b1
  } wd_state_t;
endpackage

// File: rtl/rxwd_prescaler.sv
`timescale 1ns/1ps
module rxwd_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;
  localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

  logic [PRE_W-1:0] pre_q;

  // Held at zero while idle so every run starts with a full step
  always_ff @(posedge clk) begin
    if (rst || !run_i) pre_q <= '0;
    else               pre_q <= pre_q + PRE_ONE;
  end

  assign tick_o = run_i && (pre_q == PRE_LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R4
endmodule

// File: rtl/rxwd_core.sv
`timescale 1ns/1ps
module rxwd_core
  import rxwd_pkg::*;
#(
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [RLD_W-1:0] wr_data_i,
  input  logic             frm_done_i,
  input  logic             frm_irq_req_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             fire_o
);
  localparam logic [RLD_W-1:0] CNT_ONE = RLD_W'(1);

  wd_state_t        state_q;
  logic [RLD_W-1:0] reload_q;
  logic [RLD_W-1:0] cnt_q;
  logic             fire_q;
  logic             arm_req;
  logic             cancel_req;
  logic             zero_wr;

  assign arm_req    = frm_done_i && !frm_irq_req_i && (reload_q != '0);
  assign cancel_req = frm_done_i && frm_irq_req_i;
  assign zero_wr    = wr_en_i && (wr_data_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= WD_IDLE;
      reload_q <= '0;
      cnt_q    <= '0;
      fire_q   <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (wr_en_i) reload_q <= wr_data_i;
      unique case (state_q)
        WD_IDLE: begin
          if (arm_req) begin
            state_q <= WD_RUN;
            cnt_q   <= reload_q;
          end
        end
        WD_RUN: begin
          if (cancel_req || zero_wr) begin
            state_q <= WD_IDLE;
          end else if (tick_i) begin
            if (cnt_q == CNT_ONE) begin
              state_q <= WD_IDLE;
              fire_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q - CNT_ONE;
            end
          end
        end
        default: state_q <= WD_IDLE;
      endcase
    end
  end

  assign run_o  = (state_q == WD_RUN);
  assign fire_o = fire_q;

  AST_ZERO_NO_ARM: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_IDLE && frm_done_i && reload_q == '0) |=> (state_q == WD_IDLE)); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_RUN && !tick_i) |=> (state_q == WD_IDLE || $stable(cnt_q))); // R5
  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_RUN && cancel_req) |=> (state_q == WD_IDLE && !fire_q)); // R6
  AST_ZERO_WR_STOP: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_RUN && zero_wr) |=> (state_q == WD_IDLE && !fire_q)); // R7
endmodule

// File: rtl/rx_irq_delay_timer.sv
`timescale 1ns/1ps
module rx_irq_delay_timer #(
  parameter int RLD_W = 8,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [RLD_W-1:0] cfg_wr_data,
  input  logic             frm_done,
  input  logic             frm_irq_req,
  output logic             ri_set,
  output logic             timer_active
);
  logic step_tick;
  logic core_run;
  logic core_fire;

  rxwd_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .run_i (core_run),
    .tick_o(step_tick)
  );

  rxwd_core #(.RLD_W(RLD_W)) u_core (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (cfg_wr_en),
    .wr_data_i    (cfg_wr_data),
    .frm_done_i   (frm_done),
    .frm_irq_req_i(frm_irq_req),
    .tick_i       (step_tick),
    .run_o        (core_run),
    .fire_o       (core_fire)
  );

  assign ri_set       = core_fire;
  assign timer_active = core_run;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ri_set |=> !ri_set); // R4
  AST_PULSE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    ri_set |-> (!timer_active && $past(timer_active))); // R4
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !timer_active |=> !ri_set); // R3
endmodule

// File: tb/test_rx_irq_delay_timer.sv
`timescale 1ns/1ps
module test_rx_irq_delay_timer;
  localparam int RLD_W = 8;
  localparam int STEP  = 256;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_wr_en = 1'b0;
  logic [RLD_W-1:0] cfg_wr_data = '0;
  logic             frm_done = 1'b0;
  logic             frm_irq_req = 1'b0;
  logic             ri_set;
  logic             timer_active;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  rx_irq_delay_timer #(.RLD_W(RLD_W), .PRE_W(8)) i_rx_irq_delay_timer (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .frm_done    (frm_done),
    .frm_irq_req (frm_irq_req),
    .ri_set      (ri_set),
    .timer_active(timer_active)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic write_reload(input int v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = RLD_W'(v);
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  // Frame strobe; returns at the falling edge just after the sampling edge
  task automatic frame(input bit req);
    @(negedge clk);
    frm_done = 1'b1; frm_irq_req = req;
    @(negedge clk);
    frm_done = 1'b0; frm_irq_req = 1'b0;
  endtask

  // Starts right after an arming frame (edge 1). kind: 0 none,
  // 1 suppressed frame, 2 requesting frame, 3 write zero, 4 write five.
  // Returns the edge index of the pulse, 0 if none; pulses counts all.
  task automatic watch(input int inj_at, input int kind, input int limit,
                       output int fire_edge, output int pulses);
    int passed;
    passed = 1;
    fire_edge = 0;
    pulses = 0;
    while (passed < limit) begin
      frm_done = 1'b0; frm_irq_req = 1'b0; cfg_wr_en = 1'b0;
      if (ri_set) begin
        pulses++;
        if (fire_edge == 0) fire_edge = passed;
      end
      if (passed == inj_at) begin
        case (kind)
          1: begin frm_done = 1'b1; frm_irq_req = 1'b0; end
          2: begin frm_done = 1'b1; frm_irq_req = 1'b1; end
          3: begin cfg_wr_en = 1'b1; cfg_wr_data = '0; end
          4: begin cfg_wr_en = 1'b1; cfg_wr_data = RLD_W'(5); end
          default: ;
        endcase
      end
      @(negedge clk);
      passed++;
    end
    frm_done = 1'b0; frm_irq_req = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic t_reset();
    int fe, np;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ri_set after reset", ri_set, 0);
    check("R1 timer_active after reset", timer_active, 0);
    frame(1'b0);
    check("R1 reload zero after reset, no arm", timer_active, 0);
    watch(0, 0, 400, fe, np);
    check("R1 no pulse after reset", np, 0);
  endtask

  task automatic t_expire(input int n);
    int fe, np;
    write_reload(n);
    frame(1'b0);
    check("R2 armed by suppressed completion", timer_active, 1);
    watch(0, 0, STEP * n + 300, fe, np);
    check("R4 pulse edge", fe, STEP * n + 1);
    check("R4 single pulse", np, 1);
    check("R4 idle after expiry", timer_active, 0);
  endtask

  task automatic t_zero_reload();
    int fe, np;
    write_reload(0);
    frame(1'b0);
    check("R3 zero reload stays idle", timer_active, 0);
    watch(0, 0, 600, fe, np);
    check("R3 zero reload no pulse", np, 0);
  endtask

  task automatic t_no_restart();
    int fe, np;
    write_reload(2);
    frame(1'b0);
    watch(300, 1, 900, fe, np);
    check("R5 deadline kept by first completion", fe, 2 * STEP + 1);
    check("R5 one pulse", np, 1);
  endtask

  task automatic t_cancel();
    int fe, np;
    write_reload(3);
    frame(1'b0);
    watch(400, 2, 402, fe, np);
    check("R6 stopped by requesting completion", timer_active, 0);
    watch(0, 0, 1200, fe, np);
    check("R6 no pulse after cancel", np, 0);
  endtask

  task automatic t_zero_write();
    int fe, np;
    write_reload(3);
    frame(1'b0);
    watch(100, 3, 102, fe, np);
    check("R7 stopped by zero write", timer_active, 0);
    watch(0, 0, 1200, fe, np);
    check("R7 no pulse after zero write", np, 0);
  endtask

  task automatic t_rewrite();
    int fe, np;
    write_reload(2);
    frame(1'b0);
    watch(10, 4, 900, fe, np);
    check("R8 deadline unchanged by rewrite", fe, 2 * STEP + 1);
    check("R8 one pulse", np, 1);
    frame(1'b0);
    watch(0, 0, 5 * STEP + 300, fe, np);
    check("R8 new value used on next arm", fe, 5 * STEP + 1);
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_zero_reload();
    t_expire(1);
    t_expire(3);
    t_expire(255);
    t_no_restart();
    t_cancel();
    t_zero_write();
    t_rewrite();
    summary();
    $finish;
  end
endmodule